// File: doc/BRIEF.md
# Parallel Tag/Data Cache Core

This block is a small fully associative cache core. The tag compare and the line-data storage are accessed in the same clock cycle. A requester presents a line address, with no word or byte offset, together with four command strobes: request, read/write, invalidate and replace. Each command is taken and completed in one cycle. The hit/miss flags, the returned line data and the evicted tag appear on registered outputs one cycle later.

The core does not talk to a backing memory. An outside controller watches for a miss, fetches the line elsewhere and installs it with a replace command. The core picks the victim line by least-recently-used order. In the cycle after the replace, the core hands back the victim's old data and old tag so that the controller can write them back. Line storage is read-first: a write in a cycle places the old content on the data output.

Top module: `ptd_cache_core`

## Requirements
- R1: After synchronous reset every line is invalid and `hit` and `miss` are low. A lookup of any address, including address 0, then reports a miss.
- R2: The strobes decode as follows, with {cmd_req,cmd_wr,cmd_inv,cmd_rpl} written left to right:
  - 0000 does nothing.
  - 1000 reads a line.
  - 1100 updates a line.
  - 1010 reads a line, then invalidates it.
  - 1110 writes a line, then invalidates it.
  - 0?01 replaces a line. `cmd_wr` has no effect on replace.
- R3: One cycle after a lookup command, exactly one of `hit` and `miss` is high. One cycle after any other command, both are low.
- R4: One cycle after a read that hits, `line_rdata` shows the stored content of that line.
- R5: An update that hits stores `line_wdata` into the line. One cycle later `line_rdata` shows the content the line held before the write (read-first).
- R6: A read-invalidate that hits returns the line content one cycle later and marks the line invalid. Later lookups of that address miss.
- R7: A write-invalidate that hits returns the previous line content one cycle later and marks the line invalid. Later lookups of that address miss.
- R8: Replace installs `line_wdata` under `addr` as a valid line. One cycle later, `line_rdata` and `old_addr` carry the data and tag that the victim line held.
- R9: The replace victim is the least recently used line. A line counts as used when it hits on any lookup or is installed by replace. After reset the lines are taken in the fixed order LINES-1 down to 0.
- R10: A lookup that misses changes no line content, no valid bit and no recency order.
- R11: Any strobe pattern not listed in R2 is ignored. It changes no stored state and leaves `hit` and `miss` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 1 | Lookup request strobe |
| cmd_wr | input | 1 | Write select for lookups |
| cmd_inv | input | 1 | Invalidate-after-access strobe |
| cmd_rpl | input | 1 | Replace strobe |
| addr | input | ADDR_W | Line address (no offset bits) |
| line_wdata | input | DATA_W | New line content for update, write or replace |
| hit | output | 1 | Lookup hit, one cycle after the command |
| miss | output | 1 | Lookup miss, one cycle after the command |
| line_rdata | output | DATA_W | Line content, or evicted content after replace |
| old_addr | output | ADDR_W | Tag of the evicted line after replace |

## Verification
The assertions assume the controller never replaces with an address that is already resident. Under that assumption at most one tag can match, and the one-match property holds. The bench issues replace only for addresses that its own expected state shows as absent. The recency ranks must always form a permutation, so that exactly one line carries the oldest rank. This is guaranteed from reset because the only state changes come through the defined commands. The directed tests also check the strobe patterns that decode to nothing, which the assertions treat as inert.

// File: rtl/ptd_cache_pkg.sv
package ptd_cache_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_READ,
    CMD_UPDATE,
    CMD_READ_INV,
    CMD_WRITE_INV,
    CMD_REPLACE
  } ptd_cmd_e;

  function automatic logic cmd_is_lookup(ptd_cmd_e c);
    return (c == CMD_READ) || (c == CMD_UPDATE) ||
           (c == CMD_READ_INV) || (c == CMD_WRITE_INV);
  endfunction

  function automatic logic cmd_is_write(ptd_cmd_e c);
    return (c == CMD_UPDATE) || (c == CMD_WRITE_INV);
  endfunction

  function automatic logic cmd_is_inv(ptd_cmd_e c);
    return (c == CMD_READ_INV) || (c == CMD_WRITE_INV);
  endfunction

endpackage

// File: rtl/ptd_cmd_decode.sv
module ptd_cmd_decode
  import ptd_cache_pkg::*;
(
  input  logic     req,
  input  logic     wr,
  input  logic     inv,
  input  logic     rpl,
  output ptd_cmd_e cmd
);

  // Strobe order {req,wr,inv,rpl}; unlisted patterns decode to no operation
  always_comb begin
    casez ({req, wr, inv, rpl})
      4'b1000: cmd = CMD_READ;
      4'b1100: cmd = CMD_UPDATE;
      4'b1010: cmd = CMD_READ_INV;
      4'b1110: cmd = CMD_WRITE_INV;
      4'b0?01: cmd = CMD_REPLACE;
      default: cmd = CMD_NONE;
    endcase
  end

endmodule

// File: rtl/ptd_tag_array.sv
module ptd_tag_array #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rpl_en,
  input  logic [IDX_W-1:0]  victim_idx,
  input  logic              inv_en,
  output logic              hit_any,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [ADDR_W-1:0] old_tag_q
);

  logic [ADDR_W-1:0] tags [LINES];
  logic [LINES-1:0]  valid;
  logic [LINES-1:0]  hit_vec;

  // Parallel compare against every line
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == addr);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= '0;
      old_tag_q <= '0;
      for (int i = 0; i < LINES; i++) tags[i] <= '0;
    end else begin
      if (rpl_en) begin
        tags[victim_idx]  <= addr;
        valid[victim_idx] <= 1'b1;
        old_tag_q         <= tags[victim_idx];
      end
      if (inv_en) valid[hit_idx] <= 1'b0;
    end
  end

  // R8: a stored tag matches at most one line (replace is only issued on absent addresses)
  p_single_match_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R8: a replaced line holds the new tag and is valid
  p_replace_installs_r8: assert property (@(posedge clk) disable iff (rst)
    rpl_en |=> valid[$past(victim_idx)] && (tags[$past(victim_idx)] == $past(addr)));

  // R6: invalidating access clears the matched line
  p_inv_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !rpl_en) |=> !valid[$past(hit_idx)]);

endmodule

// File: rtl/ptd_lru.sv
module ptd_lru #(
  parameter int LINES = 4,
  parameter int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

  // rank 0 = most recent, LINES-1 = least recent
  logic [IDX_W-1:0] rank [LINES];
  logic [LINES-1:0] victim_vec;
  logic [IDX_W-1:0] touch_rank;

  assign touch_rank = rank[touch_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_rank
    assign victim_vec[g] = (rank[g] == OLDEST);

    always_ff @(posedge clk) begin
      if (rst) begin
        rank[g] <= IDX_W'(g);
      end else if (touch) begin
        if (touch_idx == IDX_W'(g))
          rank[g] <= '0;
        else if (rank[g] < touch_rank)
          rank[g] <= rank[g] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (victim_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  // R9: ranks stay a permutation, so exactly one line is oldest
  p_one_victim_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot(victim_vec));

  // R9: a touched line becomes most recent
  p_touch_mru_r9: assert property (@(posedge clk) disable iff (rst)
    touch |=> (rank[$past(touch_idx)] == '0));

endmodule

// File: rtl/ptd_line_store.sv
module ptd_line_store #(
  parameter int LINES  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [LINES];

  // Single port, read-first: the output register takes the old word on a write
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[idx];
      if (we) mem[idx] <= wdata;
    end
  end

endmodule

// File: rtl/ptd_cache_core.sv
module ptd_cache_core
  import ptd_cache_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_req,
  input  logic              cmd_wr,
  input  logic              cmd_inv,
  input  logic              cmd_rpl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] line_wdata,
  output logic              hit,
  output logic              miss,
  output logic [DATA_W-1:0] line_rdata,
  output logic [ADDR_W-1:0] old_addr
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  ptd_cmd_e         cmd;
  logic             is_lookup, is_write, is_inv, is_rpl;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx, victim_idx, line_idx;
  logic             lookup_hit, store_en, store_we, inv_en;

  ptd_cmd_decode u_dec (
    .req (cmd_req),
    .wr  (cmd_wr),
    .inv (cmd_inv),
    .rpl (cmd_rpl),
    .cmd (cmd)
  );

  assign is_lookup  = cmd_is_lookup(cmd);
  assign is_write   = cmd_is_write(cmd);
  assign is_inv     = cmd_is_inv(cmd);
  assign is_rpl     = (cmd == CMD_REPLACE);
  assign lookup_hit = is_lookup && hit_any;
  assign inv_en     = lookup_hit && is_inv;
  assign line_idx   = is_rpl ? victim_idx : hit_idx;
  assign store_en   = lookup_hit || is_rpl;
  assign store_we   = (lookup_hit && is_write) || is_rpl;

  ptd_tag_array #(.LINES(LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .rpl_en     (is_rpl),
    .victim_idx (victim_idx),
    .inv_en     (inv_en),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx),
    .old_tag_q  (old_addr)
  );

  ptd_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch      (store_en),
    .touch_idx  (line_idx),
    .victim_idx (victim_idx)
  );

  ptd_line_store #(.LINES(LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .en    (store_en),
    .we    (store_we),
    .idx   (line_idx),
    .wdata (line_wdata),
    .rdata (line_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit  <= 1'b0;
      miss <= 1'b0;
    end else begin
      hit  <= lookup_hit;
      miss <= is_lookup && !hit_any;
    end
  end

  // R3: a lookup yields exactly one of hit/miss one cycle later
  p_lookup_resp_r3: assert property (@(posedge clk) disable iff (rst)
    is_lookup |=> (hit ^ miss));

  // R3, R11: non-lookup commands leave both flags low
  p_quiet_resp_r3: assert property (@(posedge clk) disable iff (rst)
    !is_lookup |=> (!hit && !miss));

  // R10: a missing lookup touches no storage
  p_miss_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (is_lookup && !hit_any) |-> !store_en);

  // R2: replace never coincides with a lookup
  p_cmd_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(is_rpl && is_lookup));

endmodule

// File: tb/ptd_cache_core_tb.sv
module ptd_cache_core_tb_top;

  localparam int LINES  = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              cmd_req, cmd_wr, cmd_inv, cmd_rpl;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] line_wdata;
  logic              hit, miss;
  logic [DATA_W-1:0] line_rdata;
  logic [ADDR_W-1:0] old_addr;

  int checks   = 0;
  int failures = 0;

  logic              o_hit, o_miss;
  logic [DATA_W-1:0] o_data;
  logic [ADDR_W-1:0] o_old;

  always #2 clk = ~clk;

  ptd_cache_core #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_wr(cmd_wr), .cmd_inv(cmd_inv),
    .cmd_rpl(cmd_rpl), .addr(addr), .line_wdata(line_wdata), .hit(hit),
    .miss(miss), .line_rdata(line_rdata), .old_addr(old_addr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; applies strobes for one cycle, samples at next falling edge
  task automatic issue(logic rq, logic w, logic iv, logic rp,
                       logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    cmd_req = rq; cmd_wr = w; cmd_inv = iv; cmd_rpl = rp;
    addr = a; line_wdata = d;
    @(negedge clk);
    o_hit = hit; o_miss = miss; o_data = line_rdata; o_old = old_addr;
    cmd_req = 0; cmd_wr = 0; cmd_inv = 0; cmd_rpl = 0;
  endtask

  task automatic t_reset();
    check("R1 hit after reset", {31'd0, hit}, 32'd0);
    check("R1 miss after reset", {31'd0, miss}, 32'd0);
    issue(1, 0, 0, 0, 8'h00, '0);
    check("R1 addr0 misses", {30'd0, o_hit, o_miss}, 32'd1);
    issue(1, 0, 0, 0, 8'h10, '0);
    check("R1 addr10 misses", {30'd0, o_hit, o_miss}, 32'd1);
  endtask

  task automatic t_fill();
    issue(0, 0, 0, 1, 8'h10, 32'hD0000010);
    check("R3 replace flags low", {30'd0, o_hit, o_miss}, 32'd0);
    issue(0, 0, 0, 1, 8'h20, 32'hD0000020);
    issue(0, 0, 0, 1, 8'h30, 32'hD0000030);
    issue(0, 0, 0, 1, 8'h40, 32'hD0000040);
    check("R9 reset order victim line0 tag", {24'd0, o_old}, 32'h0);
  endtask

  task automatic t_read_update();
    issue(1, 0, 0, 0, 8'h10, '0);
    check("R4 read hit flags", {30'd0, o_hit, o_miss}, 32'd2);
    check("R4 read data", o_data, 32'hD0000010);
    issue(1, 1, 0, 0, 8'h30, 32'hE0000030);
    check("R5 update hit", {30'd0, o_hit, o_miss}, 32'd2);
    check("R5 read-first old data", o_data, 32'hD0000030);
    issue(1, 0, 0, 0, 8'h30, '0);
    check("R5 new data stored", o_data, 32'hE0000030);
  endtask

  task automatic t_miss_and_lru();
    issue(1, 1, 0, 0, 8'h55, 32'hBAD00055);
    check("R10 missed write flags", {30'd0, o_hit, o_miss}, 32'd1);
    issue(1, 0, 0, 0, 8'h55, '0);
    check("R10 missed write not installed", {30'd0, o_hit, o_miss}, 32'd1);
    issue(0, 0, 0, 1, 8'h50, 32'hD0000050);
    check("R9 LRU victim tag", {24'd0, o_old}, 32'h20);
    check("R8 evicted data", o_data, 32'hD0000020);
    issue(1, 0, 0, 0, 8'h20, '0);
    check("R8 evicted line gone", {30'd0, o_hit, o_miss}, 32'd1);
  endtask

  task automatic t_illegal();
    issue(1, 1, 0, 1, 8'h50, 32'hBAD00050);
    check("R11 illegal flags low", {30'd0, o_hit, o_miss}, 32'd0);
    issue(0, 0, 1, 1, 8'h50, 32'hBAD10050);
    check("R11 illegal2 flags low", {30'd0, o_hit, o_miss}, 32'd0);
    issue(1, 0, 0, 0, 8'h50, '0);
    check("R11 line unchanged", o_data, 32'hD0000050);
  endtask

  task automatic t_invalidate();
    issue(1, 0, 1, 0, 8'h10, '0);
    check("R6 read-inv hit", {30'd0, o_hit, o_miss}, 32'd2);
    check("R6 read-inv data", o_data, 32'hD0000010);
    issue(1, 0, 0, 0, 8'h10, '0);
    check("R6 line now invalid", {30'd0, o_hit, o_miss}, 32'd1);
    issue(1, 1, 1, 0, 8'h40, 32'hF0000040);
    check("R7 write-inv hit", {30'd0, o_hit, o_miss}, 32'd2);
    check("R7 write-inv old data", o_data, 32'hD0000040);
    issue(1, 0, 0, 0, 8'h40, '0);
    check("R7 line now invalid", {30'd0, o_hit, o_miss}, 32'd1);
  endtask

  task automatic t_replace_chain();
    issue(0, 0, 0, 1, 8'h60, 32'hD0000060);
    check("R9 victim after inv", {24'd0, o_old}, 32'h30);
    check("R8 evicted updated data", o_data, 32'hE0000030);
    issue(0, 0, 0, 1, 8'h70, 32'hD0000070);
    check("R9 next victim", {24'd0, o_old}, 32'h50);
    check("R8 evicted data 50", o_data, 32'hD0000050);
    issue(0, 1, 0, 1, 8'h80, 32'hD0000080);
    check("R2 replace with wr=1 old tag", {24'd0, o_old}, 32'h10);
    issue(1, 0, 0, 0, 8'h80, '0);
    check("R2 replace with wr=1 installs", o_data, 32'hD0000080);
    issue(1, 0, 0, 0, 8'h60, '0);
    check("R8 installed line 60", o_data, 32'hD0000060);
    issue(1, 0, 0, 0, 8'h70, '0);
    check("R8 installed line 70 hit", {30'd0, o_hit, o_miss}, 32'd2);
    issue(0, 0, 0, 0, 8'h70, '0);
    check("R3 idle flags low", {30'd0, o_hit, o_miss}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; cmd_req = 0; cmd_wr = 0; cmd_inv = 0; cmd_rpl = 0;
    addr = '0; line_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_read_update();
    t_miss_and_lru();
    t_illegal();
    t_invalidate();
    t_replace_chain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule